// File: doc/BRIEF.md
# Process-Tagged Address Translator with Table Walk

This block turns a logical address into a physical address. It keeps a small, fully associative set of recent translations. Each stored translation carries the page number, the frame number and the identifier of the process that installed it. A lookup hits only when a valid entry holds both the incoming page number and the current process identifier. A hit is answered from the entry without any memory traffic.

On a miss the block walks the page table. It issues one read at the table base register plus the page number. It waits for the returned frame and answers with it. It also installs the new translation, filling empty slots before evicting a valid one in rotating order. While a walk is in progress the block reports busy and ignores new requests. A flush input invalidates every entry in one cycle, for use on a context switch.

Top module: `pid_tlb`

## Requirements
- R1: The logical address splits into a page number (top PAGE_W = 3 bits) and an offset (low 13 bits). The physical address is {frame, offset}, with the offset passed through unchanged. With page 2 mapped to frame 4'b1011, logical 18325 gives physical 92053.
- R2: If a valid entry matches both page and current process ID when a request is accepted, rsp_valid pulses in the next cycle with rsp_hit = 1 and the stored frame, and no memory read is issued.
- R3: An entry whose page matches but whose process ID differs from the current ID register does not hit. Entries for the same page under different IDs coexist, and each one hits under its own ID.
- R4: On a miss, mem_req pulses for exactly one cycle with mem_addr = base + page. In the cycle after mem_rvalid, rsp_valid pulses with rsp_hit = 0 and frame = mem_rdata. The new entry uses the process ID captured when the request was accepted, not the ID current at refill.
- R5: busy is high from the cycle after a miss is accepted until the response cycle. A request presented while busy produces no response and no memory read.
- R6: A refill writes the lowest-index invalid entry if one exists. Otherwise it replaces the entry under a round-robin pointer that starts at 0 and advances by one (wrapping) per replacement.
- R7: flush clears all entries in one cycle, so the next lookup of any page misses. A request accepted in the same cycle as flush is treated as a miss.
- R8: If flush coincides with the refill cycle, the response is still delivered with the fetched frame, but the entry is not installed.
- R9: Writes to the base register (base_we) and the process ID register (pid_we) take effect for requests accepted from the following cycle.
- R10: After reset, rsp_valid, busy and mem_req are low and all entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_laddr | input | LA_W | Logical address |
| busy | output | 1 | Walk in progress; requests are ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from a stored entry |
| rsp_paddr | output | FRAME_W+LA_W-PAGE_W | Physical address |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | TBASE_W | New table base |
| pid_we | input | 1 | Write strobe for the process ID register |
| pid_wdata | input | PID_W | New current process ID |
| flush | input | 1 | Invalidate all entries |
| mem_req | output | 1 | Table read request, one cycle |
| mem_addr | output | TBASE_W | Table read address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | FRAME_W | Frame number read from the table |

## Verification
Two functions can fall in the same cycle: the refill that ends a walk and a flush. The bench provokes this by waiting until it sees read data returning and raising flush in that same cycle. It then checks that the response still carries the fetched frame and that a repeat lookup of that page walks the table again. A second pairing, a flush together with a new request, is judged by whether a memory read follows for a page that was cached.

// File: rtl/pid_tlb.sv
module pid_tlb #(
  parameter int LA_W    = 16,
  parameter int PAGE_W  = 3,
  parameter int FRAME_W = 4,
  parameter int PID_W   = 4,
  parameter int ENTRIES = 4,
  parameter int TBASE_W = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic [LA_W-1:0]                   req_laddr,
  output logic                              busy,
  output logic                              rsp_valid,
  output logic                              rsp_hit,
  output logic [FRAME_W+LA_W-PAGE_W-1:0]    rsp_paddr,
  input  logic                              base_we,
  input  logic [TBASE_W-1:0]                base_wdata,
  input  logic                              pid_we,
  input  logic [PID_W-1:0]                  pid_wdata,
  input  logic                              flush,
  output logic                              mem_req,
  output logic [TBASE_W-1:0]                mem_addr,
  input  logic                              mem_rvalid,
  input  logic [FRAME_W-1:0]                mem_rdata
);
  localparam int OFF_W = LA_W - PAGE_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_v;
  logic [PAGE_W-1:0]  ent_pg  [ENTRIES];
  logic [FRAME_W-1:0] ent_fr  [ENTRIES];
  logic [PID_W-1:0]   ent_pid [ENTRIES];

  logic [TBASE_W-1:0] base_q;
  logic [PID_W-1:0]   pid_q;
  logic               walking;
  logic [PAGE_W-1:0]  lat_pg;
  logic [OFF_W-1:0]   lat_off;
  logic [PID_W-1:0]   lat_pid;
  logic [IDX_W-1:0]   rr_q;

  logic [PAGE_W-1:0]  req_pg;
  logic [OFF_W-1:0]   req_off;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   hit_idx, free_idx, slot;
  logic               any_free, accept, hit, fill, install;

  assign req_pg  = req_laddr[LA_W-1:OFF_W];
  assign req_off = req_laddr[OFF_W-1:0];
  assign busy    = walking;
  assign accept  = req_valid && !walking;
  assign hit     = (|match) && !flush;
  assign fill    = walking && mem_rvalid;
  assign install = fill && !flush;
  assign slot    = any_free ? free_idx : rr_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = ent_v[i] && (ent_pg[i] == req_pg) && (ent_pid[i] == pid_q);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
      if (!ent_v[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      pid_q  <= '0;
    end else begin
      if (base_we) base_q <= base_wdata;
      if (pid_we)  pid_q  <= pid_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walking   <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      lat_pg    <= '0;
      lat_off   <= '0;
      lat_pid   <= '0;
    end else begin
      mem_req   <= 1'b0;
      rsp_valid <= 1'b0;
      if (accept) begin
        if (hit) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_paddr <= {ent_fr[hit_idx], req_off};
        end else begin
          walking  <= 1'b1;
          mem_req  <= 1'b1;
          mem_addr <= base_q + TBASE_W'(req_pg);
          lat_pg   <= req_pg;
          lat_off  <= req_off;
          lat_pid  <= pid_q;
        end
      end else if (fill) begin
        walking   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b0;
        rsp_paddr <= {mem_rdata, lat_off};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      rr_q  <= '0;
    end else begin
      if (install) begin
        ent_v[slot] <= 1'b1;
        if (!any_free) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
      if (flush) ent_v <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      ent_pg[slot]  <= lat_pg;
      ent_fr[slot]  <= mem_rdata;
      ent_pid[slot] <= lat_pid;
    end
  end

  AST_HIT_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (rsp_valid && rsp_hit && !mem_req)); // R2
  AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (mem_req && busy && !rsp_valid)); // R4
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R4
  AST_FILL_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (rsp_valid && !rsp_hit && !busy)); // R4
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rvalid) |=> (!rsp_valid && !mem_req)); // R5
  AST_NO_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R3
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_v == '0)); // R7
  AST_FLUSH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && flush) |=> (rsp_valid && ent_v == '0)); // R8
endmodule

// File: tb/pid_tlb_test.sv
module pid_tlb_test;
  localparam int LA_W = 16, PAGE_W = 3, FRAME_W = 4, PID_W = 4, ENTRIES = 4, TBASE_W = 12;
  localparam int OFF_W = LA_W - PAGE_W;
  localparam int PA_W = FRAME_W + OFF_W;
  localparam int LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [LA_W-1:0] req_laddr = '0;
  logic busy, rsp_valid, rsp_hit, mem_req;
  logic [PA_W-1:0] rsp_paddr;
  logic base_we = 1'b0, pid_we = 1'b0, flush = 1'b0;
  logic [TBASE_W-1:0] base_wdata = '0, mem_addr;
  logic [PID_W-1:0] pid_wdata = '0;
  logic mem_rvalid;
  logic [FRAME_W-1:0] mem_rdata;

  int checks = 0, fails = 0;
  int rd_cnt;
  logic [TBASE_W-1:0] last_addr, addr_l;
  int lat_cnt;
  logic [TBASE_W-1:0] base_cur = '0;

  always #5 clk = ~clk;

  pid_tlb #(.LA_W(LA_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .PID_W(PID_W),
            .ENTRIES(ENTRIES), .TBASE_W(TBASE_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .base_we(base_we), .base_wdata(base_wdata), .pid_we(pid_we), .pid_wdata(pid_wdata),
    .flush(flush), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  function automatic logic [FRAME_W-1:0] table_frame(logic [TBASE_W-1:0] a);
    return a[3:0] ^ a[7:4];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      rd_cnt     <= 0;
      lat_cnt    <= 0;
      last_addr  <= '0;
      addr_l     <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
        lat_cnt   <= LAT;
        addr_l    <= mem_addr;
        last_addr <= mem_addr;
        rd_cnt    <= rd_cnt + 1;
      end else if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= table_frame(addr_l);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_pid(input logic [PID_W-1:0] v);
    @(negedge clk); pid_we = 1'b1; pid_wdata = v;
    @(negedge clk); pid_we = 1'b0;
  endtask

  task automatic set_base(input logic [TBASE_W-1:0] v);
    @(negedge clk); base_we = 1'b1; base_wdata = v; base_cur = v;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic lookup(input logic [PAGE_W-1:0] pg, input logic [OFF_W-1:0] off,
                        input bit exp_hit, input string req);
    int n = 0;
    int rd0;
    logic [PA_W-1:0] exp_pa;
    exp_pa = {table_frame(base_cur + TBASE_W'(pg)), off};
    @(negedge clk);
    rd0 = rd_cnt;
    req_valid = 1'b1; req_laddr = {pg, off};
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
    check(rsp_valid, req, "response seen", rsp_valid, 1);
    check(rsp_hit == exp_hit, req, "hit flag", rsp_hit, exp_hit);
    check(rsp_paddr == exp_pa, req, "physical address", rsp_paddr, exp_pa);
    if (exp_hit) begin
      check(n == 0, req, "hit latency", n, 0);
      check(rd_cnt == rd0, req, "no read on hit", rd_cnt - rd0, 0);
    end else begin
      check(rd_cnt == rd0 + 1, req, "one table read", rd_cnt - rd0, 1);
      check(last_addr == base_cur + TBASE_W'(pg), req, "table address",
            last_addr, base_cur + TBASE_W'(pg));
    end
  endtask

  task automatic t_reset();
    check(!rsp_valid && !busy && !mem_req, "R10", "idle outputs after reset",
          {rsp_valid, busy, mem_req}, 0);
  endtask

  task automatic t_translate();
    set_pid(4'd1);
    set_base(12'h009);
    @(negedge clk); req_valid = 1'b1; req_laddr = 16'd18325;
    @(negedge clk); req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check(rsp_paddr == 17'd92053, "R1", "worked translation", rsp_paddr, 92053);
    check(!rsp_hit, "R4", "first access misses", rsp_hit, 0);
    lookup(3'd2, 13'h0795, 1'b1, "R2");
    lookup(3'd2, 13'h1FFF, 1'b1, "R1");
  endtask

  task automatic t_pid();
    set_pid(4'd2);
    lookup(3'd2, 13'h0100, 1'b0, "R3");
    set_pid(4'd1);
    lookup(3'd2, 13'h0101, 1'b1, "R3");
    set_pid(4'd2);
    lookup(3'd2, 13'h0102, 1'b1, "R3");
  endtask

  task automatic t_busy();
    int rd0;
    set_pid(4'd1);
    @(negedge clk);
    rd0 = rd_cnt;
    req_valid = 1'b1; req_laddr = {3'd3, 13'h0042};
    @(negedge clk);
    req_valid = 1'b0;
    check(busy, "R5", "busy during walk", busy, 1);
    @(negedge clk);
    req_valid = 1'b1; req_laddr = {3'd6, 13'h0001};
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check(rsp_paddr == {table_frame(base_cur + 12'd3), 13'h0042}, "R5", "walk result",
          rsp_paddr, {table_frame(base_cur + 12'd3), 13'h0042});
    check(!busy, "R5", "busy drops with response", busy, 0);
    repeat (LAT + 3) begin
      @(negedge clk);
      check(!rsp_valid, "R5", "no response to ignored request", rsp_valid, 0);
    end
    check(rd_cnt == rd0 + 1, "R5", "ignored request read nothing", rd_cnt - rd0, 1);
  endtask

  task automatic t_replace();
    pulse_flush();
    for (int p = 0; p < 4; p++) lookup(3'(p), 13'(p), 1'b0, "R6");
    for (int p = 0; p < 4; p++) lookup(3'(p), 13'(p), 1'b1, "R6");
    lookup(3'd4, 13'h0010, 1'b0, "R6");
    lookup(3'd1, 13'h0011, 1'b1, "R6");
    lookup(3'd0, 13'h0012, 1'b0, "R6");
    lookup(3'd2, 13'h0013, 1'b1, "R6");
    lookup(3'd1, 13'h0014, 1'b0, "R6");
    lookup(3'd3, 13'h0015, 1'b1, "R6");
    lookup(3'd4, 13'h0016, 1'b1, "R6");
    lookup(3'd2, 13'h0017, 1'b0, "R6");
  endtask

  task automatic t_flush();
    int rd0;
    pulse_flush();
    lookup(3'd3, 13'h0020, 1'b0, "R7");
    @(negedge clk);
    rd0 = rd_cnt;
    req_valid = 1'b1; req_laddr = {3'd3, 13'h0021}; flush = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b0;
    check(mem_req, "R7", "request with flush walks", mem_req, 1);
    while (!rsp_valid) @(negedge clk);
    check(!rsp_hit && rd_cnt == rd0 + 1, "R7", "flush-cycle request missed",
          rsp_hit, 0);
  endtask

  task automatic t_flush_fill();
    logic [PA_W-1:0] exp_pa;
    exp_pa = {table_frame(base_cur + 12'd5), 13'h0ABC};
    @(negedge clk);
    req_valid = 1'b1; req_laddr = {3'd5, 13'h0ABC};
    @(negedge clk);
    req_valid = 1'b0;
    while (!mem_rvalid) @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(rsp_valid, "R8", "response despite flush", rsp_valid, 1);
    check(rsp_paddr == exp_pa, "R8", "fetched frame delivered", rsp_paddr, exp_pa);
    lookup(3'd5, 13'h0ABD, 1'b0, "R8");
  endtask

  task automatic t_registers();
    set_pid(4'd1);
    lookup(3'd6, 13'h0003, 1'b0, "R4");
    @(negedge clk);
    req_valid = 1'b1; req_laddr = {3'd7, 13'h0004};
    @(negedge clk);
    req_valid = 1'b0;
    pid_we = 1'b1; pid_wdata = 4'd3;
    @(negedge clk);
    pid_we = 1'b0;
    while (!rsp_valid) @(negedge clk);
    lookup(3'd7, 13'h0005, 1'b0, "R4");
    set_pid(4'd1);
    lookup(3'd7, 13'h0006, 1'b1, "R4");
    set_base(12'h020);
    pulse_flush();
    lookup(3'd2, 13'h0007, 1'b0, "R9");
    check(rsp_paddr[PA_W-1:OFF_W] == 4'h0, "R9", "frame from new base",
          rsp_paddr[PA_W-1:OFF_W], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_translate();
    t_pid();
    t_busy();
    t_replace();
    t_flush();
    t_flush_fill();
    t_registers();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule